// File: doc/BRIEF.md
# Coprocessor Access Trap Syndrome Encoder

This block forms the 25-bit syndrome word reported when a 32-bit coprocessor register move, a coprocessor load/store, or a floating-point / SIMD system access is trapped. The pipeline presents the trapped instruction word, a trap class code, a 5-bit condition field and the current processor mode, together with a one-cycle request strobe. One clock later the block presents the packed syndrome with a one-cycle valid pulse.

The layout of the low 20 bits depends on the trap class. A single-register move copies its opcode and register-number fields. A double-register move reports two general register indices. A load/store reports its immediate and addressing bits. Where a general register is named, the 4-bit register number is translated by a small mode-dependent remap into a 5-bit index. Operands naming register 15 do not go through the remap: they produce either all ones or zero. An unknown class code raises an error flag and clears the syndrome.

Top module: `ctrap_syndrome_enc`

## Requirements
- R1: A request sampled at a rising edge makes `syn_valid` high for exactly the cycle after that edge, with `syn_word` and `syn_err` updated in the same cycle. Synchronous reset clears `syn_valid`, `syn_word` and `syn_err`.
- R2: Accepted class codes are 0x0 (unknown reason), 0x3 and 0x5 (single-register move), 0x4, 0x7 and 0xC (double-register move), 0x6 (load/store) and 0x8 (FP ID read). Any other code sets `syn_err` and makes the whole `syn_word` zero.
- R3: For a single-register move, the syndrome fields are filled from the instruction as follows: [19:17] from instr[7:5], [16:14] from instr[23:21], [13:10] from instr[19:16], and [4:1] from instr[3:0]. Bit 15 is zero.
- R4: For an FP ID read, [19:17]=000, [16:14]=111 and [4:1]=0000. Field [13:10] comes from instr[19:16].
- R5: For single-register moves and FP ID reads, field [9:5] is the remapped index of instr[15:12]. The exception is instr[15:12]=15: the field is then 11111 if instr[20]=1 and 00000 if instr[20]=0.
- R6: The remap leaves registers 0-7 and 15 unchanged. In mode 10001, registers 8-14 become 24-30. Registers 13 and 14 become 17 and 16 in mode 10010, 19 and 18 in mode 10011, 21 and 20 in mode 10111, and 23 and 22 in mode 11011. Every other case is unchanged.
- R7: For a double-register move, the fields are: [19:16] from instr[7:4]; [15]=0; [14:10] the remapped instr[19:16]; [9:5] the remapped instr[15:12]; [4:1] from instr[3:0]. An operand equal to 15 gives 00000 in its field.
- R8: For a load/store, the fields are: [19:12] from instr[7:0]; [11:5]=0; [4] from instr[23]; [3]=1 exactly when instr[19:16]=15; [2] from instr[24]; [1] from instr[21].
- R9: For class 0x0, [9:5] is the remapped instr[19:16]. Bits [19:10] and [4:1] are zero.
- R10: For every accepted class, bit 0 equals instr[20] and bits [24:20] equal the condition input.
- R11: Between requests, `syn_word` and `syn_err` hold their last values and `syn_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; inputs are sampled when high |
| instr | input | 32 | Trapped instruction word |
| cls_code | input | 6 | Trap class code |
| cond | input | 5 | Condition field for the syndrome top bits |
| mode | input | 5 | Current processor mode, used by the register remap |
| syn_valid | output | 1 | One-cycle pulse marking a new syndrome |
| syn_word | output | 25 | Packed syndrome |
| syn_err | output | 1 | Illegal class code seen on the last request |

## Verification
A wrong class decode, a misrouted field or a wrong remap entry produces a wrong `syn_word` in the very cycle of the valid pulse, one edge after the request. No internal state builds up across requests. A sweep of every class code against all sixteen values of the transfer register, in each mode, therefore exposes a fault on the first request that uses it. A corrupted output register shows up either as a valid pulse without a request or as syndrome bits that change while no request is present.

// File: rtl/ctrap_pkg.sv
package ctrap_pkg;
  typedef enum logic [2:0] {
    K_UNCAT  = 3'd0,
    K_SINGLE = 3'd1,
    K_DOUBLE = 3'd2,
    K_LDST   = 3'd3,
    K_FPID   = 3'd4,
    K_BAD    = 3'd5
  } trap_kind_e;

  localparam logic [4:0] MODE_FAST  = 5'b10001;
  localparam logic [4:0] MODE_INTR  = 5'b10010;
  localparam logic [4:0] MODE_SUPV  = 5'b10011;
  localparam logic [4:0] MODE_ABRT  = 5'b10111;
  localparam logic [4:0] MODE_UNDEF = 5'b11011;
endpackage

// File: rtl/ctrap_class_decode.sv
module ctrap_class_decode
  import ctrap_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output trap_kind_e        kind
);
  always_comb begin
    case (code)
      CODE_W'(6'h00): kind = K_UNCAT;
      CODE_W'(6'h03),
      CODE_W'(6'h05): kind = K_SINGLE;
      CODE_W'(6'h04),
      CODE_W'(6'h07),
      CODE_W'(6'h0C): kind = K_DOUBLE;
      CODE_W'(6'h06): kind = K_LDST;
      CODE_W'(6'h08): kind = K_FPID;
      default:        kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/ctrap_reg_remap.sv
module ctrap_reg_remap
  import ctrap_pkg::*;
#(
  parameter int MODE_W = 5,
  parameter int IDX_W  = 5
) (
  input  logic [3:0]        reg_num,
  input  logic [MODE_W-1:0] mode,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] base;
  logic             banked_pair;

  always_comb begin
    base = '0;
    unique case (mode[4:0])
      MODE_INTR:  base = IDX_W'(16);
      MODE_SUPV:  base = IDX_W'(18);
      MODE_ABRT:  base = IDX_W'(20);
      MODE_UNDEF: base = IDX_W'(22);
      default:    base = '0;
    endcase
  end

  assign banked_pair = (reg_num == 4'd13) || (reg_num == 4'd14);

  always_comb begin
    idx = IDX_W'(reg_num);
    if (reg_num[3] && reg_num != 4'd15) begin
      if (mode[4:0] == MODE_FAST)
        idx = IDX_W'(reg_num) + IDX_W'(16);
      else if (banked_pair && base != '0)
        idx = base + ((reg_num == 4'd13) ? IDX_W'(1) : IDX_W'(0));
    end
  end
endmodule

// File: rtl/ctrap_field_pack.sv
module ctrap_field_pack
  import ctrap_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int COND_W  = 5,
  parameter int IDX_W   = 5,
  localparam int SYN_W  = COND_W + 20
) (
  input  trap_kind_e         kind,
  input  logic [INSTR_W-1:0] instr,
  input  logic [COND_W-1:0]  cond,
  input  logic [IDX_W-1:0]   idx_rt,
  input  logic [IDX_W-1:0]   idx_rn,
  output logic [SYN_W-1:0]   syn,
  output logic               err
);
  logic rt_is_pc, rn_is_pc, dir;

  assign rt_is_pc = (instr[15:12] == 4'hF);
  assign rn_is_pc = (instr[19:16] == 4'hF);
  assign dir      = instr[20];

  always_comb begin
    syn = '0;
    err = 1'b0;
    case (kind)
      K_SINGLE, K_FPID: begin
        if (kind == K_FPID) begin
          syn[16:14] = 3'b111;
        end else begin
          syn[19:17] = instr[7:5];
          syn[16:14] = instr[23:21];
          syn[4:1]   = instr[3:0];
        end
        syn[13:10] = instr[19:16];
        if (rt_is_pc) syn[9:5] = dir ? 5'b11111 : 5'b00000;
        else          syn[9:5] = idx_rt[4:0];
      end
      K_DOUBLE: begin
        syn[19:16] = instr[7:4];
        syn[14:10] = rn_is_pc ? 5'b00000 : idx_rn[4:0];
        syn[9:5]   = rt_is_pc ? 5'b00000 : idx_rt[4:0];
        syn[4:1]   = instr[3:0];
      end
      K_LDST: begin
        syn[19:12] = instr[7:0];
        syn[4]     = instr[23];
        syn[3]     = rn_is_pc;
        syn[2]     = instr[24];
        syn[1]     = instr[21];
      end
      K_UNCAT: begin
        syn[9:5] = idx_rn[4:0];
      end
      default: err = 1'b1;
    endcase
    if (!err) begin
      syn[SYN_W-1 -: COND_W] = cond;
      syn[0]                 = dir;
    end
  end
endmodule

// File: rtl/ctrap_syndrome_enc.sv
module ctrap_syndrome_enc
  import ctrap_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CODE_W  = 6,
  parameter int COND_W  = 5,
  parameter int MODE_W  = 5,
  parameter int IDX_W   = 5,
  localparam int SYN_W  = COND_W + 20,
  localparam int N_RMAP = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [INSTR_W-1:0] instr,
  input  logic [CODE_W-1:0]  cls_code,
  input  logic [COND_W-1:0]  cond,
  input  logic [MODE_W-1:0]  mode,
  output logic               syn_valid,
  output logic [SYN_W-1:0]   syn_word,
  output logic               syn_err
);
  trap_kind_e       kind;
  logic [3:0]       rsel [N_RMAP];
  logic [IDX_W-1:0] ridx [N_RMAP];
  logic [SYN_W-1:0] syn_d;
  logic             err_d;

  assign rsel[0] = instr[15:12];
  assign rsel[1] = instr[19:16];

  ctrap_class_decode #(.CODE_W(CODE_W)) u_dec (
    .code (cls_code),
    .kind (kind)
  );

  for (genvar g = 0; g < N_RMAP; g++) begin : g_rmap
    ctrap_reg_remap #(.MODE_W(MODE_W), .IDX_W(IDX_W)) u_rmap (
      .reg_num (rsel[g]),
      .mode    (mode),
      .idx     (ridx[g])
    );
  end

  ctrap_field_pack #(.INSTR_W(INSTR_W), .COND_W(COND_W), .IDX_W(IDX_W)) u_pack (
    .kind   (kind),
    .instr  (instr),
    .cond   (cond),
    .idx_rt (ridx[0]),
    .idx_rn (ridx[1]),
    .syn    (syn_d),
    .err    (err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_valid <= 1'b0;
      syn_word  <= '0;
      syn_err   <= 1'b0;
    end else begin
      syn_valid <= req;
      if (req) begin
        syn_word <= syn_d;
        syn_err  <= err_d;
      end
    end
  end
endmodule

// File: rtl/ctrap_syndrome_chk.sv
module ctrap_syndrome_chk #(
  parameter int INSTR_W = 32,
  parameter int CODE_W  = 6,
  parameter int COND_W  = 5,
  parameter int SYN_W   = 25
) (
  input logic               clk,
  input logic               rst,
  input logic               req,
  input logic [INSTR_W-1:0] instr,
  input logic [CODE_W-1:0]  cls_code,
  input logic [COND_W-1:0]  cond,
  input logic               syn_valid,
  input logic [SYN_W-1:0]   syn_word,
  input logic               syn_err
);
  a_r1_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    req |=> syn_valid);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!syn_valid && !syn_err && syn_word == '0));
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req |=> !syn_valid);
  a_r11_hold_word: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(syn_word) && $stable(syn_err)));
  a_r2_err_zero_word: assert property (@(posedge clk) disable iff (rst)
    (syn_valid && syn_err) |-> syn_word == '0);
  a_r10_dir_bit: assert property (@(posedge clk) disable iff (rst)
    (req ##1 (syn_valid && !syn_err)) |-> syn_word[0] == $past(instr[20]));
  a_r10_cond_field: assert property (@(posedge clk) disable iff (rst)
    (req ##1 (syn_valid && !syn_err)) |-> syn_word[SYN_W-1 -: COND_W] == $past(cond));
  a_r2_legal_no_err: assert property (@(posedge clk) disable iff (rst)
    (req && cls_code == CODE_W'(6'h03)) |=> !syn_err);
endmodule

bind ctrap_syndrome_enc ctrap_syndrome_chk #(
  .INSTR_W(INSTR_W), .CODE_W(CODE_W), .COND_W(COND_W), .SYN_W(SYN_W)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .instr(instr), .cls_code(cls_code),
  .cond(cond), .syn_valid(syn_valid), .syn_word(syn_word), .syn_err(syn_err)
);

// File: tb/ctrap_syndrome_enc_bench.sv
module ctrap_syndrome_enc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [31:0] instr = '0;
  logic [5:0]  cls_code = '0;
  logic [4:0]  cond = '0;
  logic [4:0]  mode = 5'b10000;
  logic        syn_valid;
  logic [24:0] syn_word;
  logic        syn_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctrap_syndrome_enc u_ctrap_syndrome_enc (
    .clk(clk), .rst(rst), .req(req), .instr(instr), .cls_code(cls_code),
    .cond(cond), .mode(mode), .syn_valid(syn_valid), .syn_word(syn_word),
    .syn_err(syn_err)
  );

  function automatic logic [4:0] bidx(input logic [3:0] r, input logic [4:0] m);
    if (r < 8 || r == 15) return {1'b0, r};
    if (m == 5'b10001) return 5'd16 + {1'b0, r};
    if (r == 13 || r == 14) begin
      case (m)
        5'b10010: return (r == 13) ? 5'd17 : 5'd16;
        5'b10011: return (r == 13) ? 5'd19 : 5'd18;
        5'b10111: return (r == 13) ? 5'd21 : 5'd20;
        5'b11011: return (r == 13) ? 5'd23 : 5'd22;
        default:  return {1'b0, r};
      endcase
    end
    return {1'b0, r};
  endfunction

  function automatic logic [25:0] expect_of(input logic [5:0] c, input logic [31:0] i,
                                            input logic [4:0] cd, input logic [4:0] m);
    logic [24:0] s;
    logic [3:0] rt, rn;
    rt = i[15:12];
    rn = i[19:16];
    s = {cd, 20'd0} | 25'(i[20]);
    case (c)
      6'h03, 6'h05, 6'h08: begin
        if (c == 6'h08) s = s | (25'd7 << 14);
        else s = s | (25'(i[7:5]) << 17) | (25'(i[23:21]) << 14) | (25'(i[3:0]) << 1);
        s = s | (25'(rn) << 10);
        if (rt == 15) s = s | (i[20] ? (25'd31 << 5) : 25'd0);
        else s = s | (25'(bidx(rt, m)) << 5);
      end
      6'h04, 6'h07, 6'h0C: begin
        s = s | (25'(i[7:4]) << 16) | (25'(i[3:0]) << 1);
        if (rn != 15) s = s | (25'(bidx(rn, m)) << 10);
        if (rt != 15) s = s | (25'(bidx(rt, m)) << 5);
      end
      6'h06: begin
        s = s | (25'(i[7:0]) << 12) | (25'(i[23]) << 4) | (25'(i[24]) << 2) | (25'(i[21]) << 1);
        if (rn == 15) s = s | 25'd8;
      end
      6'h00: s = s | (25'(bidx(rn, m)) << 5);
      default: return {1'b1, 25'd0};
    endcase
    return {1'b0, s};
  endfunction

  function automatic string tag_of(input logic [5:0] c, input logic [3:0] rt, input logic [3:0] rn);
    case (c)
      6'h03, 6'h05: return (rt == 15) ? "R5" : "R3";
      6'h08:        return (rt == 15) ? "R5" : "R4";
      6'h04, 6'h07, 6'h0C: return "R7";
      6'h06:        return (rn == 15) ? "R8 base15" : "R8";
      6'h00:        return "R9";
      default:      return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [25:0] act, input logic [25:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual err=%0b word=%07h, expected err=%0b word=%07h",
               tag, act[25], act[24:0], exp[25], exp[24:0]);
    end
  endtask

  task automatic one_req(input logic [5:0] c, input logic [31:0] i,
                         input logic [4:0] cd, input logic [4:0] m);
    logic [25:0] e;
    @(negedge clk);
    req = 1'b1; cls_code = c; instr = i; cond = cd; mode = m;
    @(negedge clk);
    req = 1'b0;
    e = expect_of(c, i, cd, m);
    check("R1 valid", {25'd0, syn_valid}, 26'd1);
    check(tag_of(c, i[15:12], i[19:16]), {syn_err, syn_word}, e);
    instr = ~i; cond = ~cd; cls_code = c ^ 6'h15;
    @(negedge clk);
    check("R11 hold", {syn_err, syn_word}, e);
    check("R11 valid low", {25'd0, syn_valid}, 26'd0);
  endtask

  initial begin
    logic [4:0] modes [8];
    logic [5:0] codes [18];
    modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
              5'b10111, 5'b11011, 5'b11111, 5'b11010};
    for (int k = 0; k < 16; k++) codes[k] = 6'(k);
    codes[16] = 6'h18;
    codes[17] = 6'h3F;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {25'd0, syn_valid}, 26'd0);
    check("R1 reset word", {syn_err, syn_word}, 26'd0);
    rst = 1'b0;
    for (int ci = 0; ci < 18; ci++) begin
      for (int mi = 0; mi < 8; mi++) begin
        for (int r = 0; r < 16; r++) begin
          logic [31:0] w;
          logic [3:0] rn;
          w = 32'h9E37_79B1 * 32'(ci * 131 + mi * 17 + r + 1);
          rn = 4'((r * 7 + ci + mi) & 15);
          w[15:12] = 4'(r);
          w[19:16] = rn;
          w[20] = w[20] ^ r[0];
          one_req(codes[ci], w, 5'((r + mi * 3) & 31), modes[mi]);
        end
        // R6 and R7: both operands 15, and both banked
        one_req(codes[ci], 32'h00FF_F0A5, 5'd9, modes[mi]);
        one_req(codes[ci], 32'h01DE_D03C, 5'd30, modes[mi]);
      end
    end
    // back-to-back requests: R1 each valid pulse carries the newest word
    @(negedge clk);
    req = 1'b1; cls_code = 6'h06; instr = 32'h0198_F0C3; cond = 5'd3; mode = 5'b10000;
    @(negedge clk);
    check("R8 b2b first", {syn_err, syn_word}, expect_of(6'h06, 32'h0198_F0C3, 5'd3, 5'b10000));
    cls_code = 6'h3A;
    @(negedge clk);
    req = 1'b0;
    check("R2 b2b second", {syn_err, syn_word}, {1'b1, 25'd0});
    check("R1 b2b valid", {25'd0, syn_valid}, 26'd1);
    // reset mid-stream clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after run", {syn_err, syn_word}, 26'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule